// File: doc/BRIEF.md
# Ethernet PAUSE Flow Control Controller

This block decides when a 10/100 Ethernet transmitter must emit an IEEE 802.3 PAUSE frame and which quanta value that frame carries. It does not build frames, append a CRC or parse received PAUSE frames. It raises a request toward the MAC transmitter and holds it until the transmitter reports that the frame has gone out. All interval counting is in the transmit clock domain, which runs at 2.5 MHz at 10 Mbps and at 25 MHz at 100 Mbps.

Two sources can ask for flow control. A manual enable asserts it directly. An automatic enable asserts it from the receive buffer count, using full and empty thresholds with hysteresis. While flow control stays asserted and the programmed quanta is nonzero, the frame is sent again every 64 × quanta transmit clocks, which is half of 128 × quanta. When flow control is withdrawn, one release frame with quanta zero tells the link partner to resume. A global enable that goes low drops everything at once and sends no release frame.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, and one cycle after `enable` is sampled low, `req_valid` is 0. Clearing through `enable` discards any pending request and never issues a quanta-zero release frame.
- R2: On the first clock edge that samples `manual_en` high while flow control is inactive and no request is outstanding, `req_valid` rises with `req_quanta` equal to `pause_time` as sampled at that edge.
- R3: While `req_valid` is 1 and `tx_ack` is 0, `req_valid` and `req_quanta` stay unchanged. An edge that samples both `req_valid` and `tx_ack` high lowers `req_valid`.
- R4: While flow control stays asserted and the acknowledged quanta Q is nonzero, the next request rises exactly 64·Q clock edges after the acknowledging edge. It carries the `pause_time` value sampled at that edge.
- R5: If the acknowledged quanta is zero, no periodic resend follows.
- R6: When flow control is withdrawn (no source wants it any more, and no request is outstanding), one request with `req_quanta` = 0x0000 is issued.
- R7: In automatic mode, a `buf_count` sampled at or above `full_mark` sets an internal hold at that edge. The pause request rises at the following edge, which is two edges after the count is applied.
- R8: The automatic hold stays set while `buf_count` lies strictly between the two marks. It clears when the count is at or below `empty_mark`, and the release frame follows one edge later. If both conditions hold at once, the full condition wins.
- R9: Manual mode has priority. Turning `manual_en` on while the automatic hold is active issues no extra frame. Turning it off while the automatic hold remains set issues no release frame.
- R10: `pause_time` is sampled only when a request starts. Changes while a request is pending do not alter `req_quanta`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global module enable; low clears all state |
| manual_en | input | 1 | Manual flow-control request |
| auto_en | input | 1 | Automatic (watermark) flow control enable |
| pause_time | input | 16 | Quanta value placed in pause frames |
| buf_count | input | COUNT_W | Current receive buffer count |
| full_mark | input | COUNT_W | Threshold at or above which flow control is asserted |
| empty_mark | input | COUNT_W | Threshold at or below which flow control is withdrawn |
| tx_ack | input | 1 | Transmitter reports the requested frame was sent |
| req_valid | output | 1 | PAUSE frame request, held until acknowledged |
| req_quanta | output | 16 | Quanta for the requested frame |

## Verification
Four properties are checked on every cycle: the request handshake (a request holds steady until acknowledged and drops after the acknowledge), the clearing effect of the global enable, the quanta carried by a request that manual mode starts, and the zero quanta of any request that starts with both modes off. Some behaviour only the bench scenarios can show. These are the exact resend spacing of 64·Q cycles, the absence of resends for zero quanta, the two-edge latency and hysteresis of automatic mode, and the manual-over-automatic priority. The bench also checks that a disabled block never emits a release frame.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int PFC_QW = 16;

    typedef struct packed {
        logic              req_valid;
        logic [PFC_QW-1:0] quanta;
        logic              active;
    } pfc_ctl_t;
endpackage

// File: rtl/pfc_watermark.sv
module pfc_watermark #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               auto_en,
    input  logic [COUNT_W-1:0] count,
    input  logic [COUNT_W-1:0] full_mark,
    input  logic [COUNT_W-1:0] empty_mark,
    output logic               hold
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!enable || !auto_en) begin
            hold_d = 1'b0;
        end else if (count >= full_mark) begin
            hold_d = 1'b1;
        end else if (count <= empty_mark) begin
            hold_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    assign hold = hold_q;
endmodule

// File: rtl/pfc_interval_timer.sv
module pfc_interval_timer #(
    parameter int TW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = load_val - TW'(1);
        end else if (expire) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int COUNT_W        = 8,
    parameter int INTERVAL_SHIFT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               manual_en,
    input  logic               auto_en,
    input  logic [PFC_QW-1:0]  pause_time,
    input  logic [COUNT_W-1:0] buf_count,
    input  logic [COUNT_W-1:0] full_mark,
    input  logic [COUNT_W-1:0] empty_mark,
    input  logic               tx_ack,
    output logic               req_valid,
    output logic [PFC_QW-1:0]  req_quanta
);
    localparam int TW = PFC_QW + INTERVAL_SHIFT;

    pfc_ctl_t ctl_d, ctl_q;
    logic          auto_hold;
    logic          want;
    logic          tmr_clear, tmr_load, tmr_expire;
    logic [TW-1:0] tmr_val;

    pfc_watermark #(.COUNT_W(COUNT_W)) u_wm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .auto_en   (auto_en),
        .count     (buf_count),
        .full_mark (full_mark),
        .empty_mark(empty_mark),
        .hold      (auto_hold)
    );

    pfc_interval_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    // manual wins by construction of the OR: the auto path never withdraws it
    assign want    = manual_en || (auto_en && auto_hold);
    assign tmr_val = TW'(ctl_q.quanta) << INTERVAL_SHIFT;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_clear = 1'b0;
        tmr_load  = 1'b0;
        if (!enable) begin
            ctl_d     = '0;
            tmr_clear = 1'b1;
        end else if (ctl_q.req_valid) begin
            if (tx_ack) begin
                ctl_d.req_valid = 1'b0;
                if (ctl_q.active && want && (ctl_q.quanta != '0)) begin
                    tmr_load = 1'b1;
                end
            end
        end else if (want && !ctl_q.active) begin
            ctl_d.req_valid = 1'b1;
            ctl_d.quanta    = pause_time;
            ctl_d.active    = 1'b1;
        end else if (!want && ctl_q.active) begin
            ctl_d.req_valid = 1'b1;
            ctl_d.quanta    = '0;
            ctl_d.active    = 1'b0;
            tmr_clear       = 1'b1;
        end else if (want && tmr_expire) begin
            ctl_d.req_valid = 1'b1;
            ctl_d.quanta    = pause_time;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_valid  = ctl_q.req_valid;
    assign req_quanta = ctl_q.quanta;
endmodule

// File: rtl/pfc_checks.sv
module pfc_checks #(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          manual_en,
    input logic          auto_en,
    input logic [QW-1:0] pause_time,
    input logic          tx_ack,
    input logic          req_valid,
    input logic [QW-1:0] req_quanta
);
    // R3
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tx_ack && enable) |=> (req_valid && $stable(req_quanta)));

    // R3
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tx_ack) |=> !req_valid);

    // R1
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !req_valid);

    // R2
    manual_quanta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && $past(manual_en)) |-> (req_quanta == $past(pause_time)));

    // R6
    release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && !$past(manual_en) && !$past(auto_en)) |-> (req_quanta == '0));
endmodule

bind pause_flow_ctrl pfc_checks #(.QW(pfc_pkg::PFC_QW)) u_pfc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .manual_en (manual_en),
    .auto_en   (auto_en),
    .pause_time(pause_time),
    .tx_ack    (tx_ack),
    .req_valid (req_valid),
    .req_quanta(req_quanta)
);

// File: tb/pause_flow_ctrl_tb_top.sv
module pause_flow_ctrl_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          manual_en = 1'b0;
    logic          auto_en = 1'b0;
    logic [15:0]   pause_time = '0;
    logic [CW-1:0] buf_count = '0;
    logic [CW-1:0] full_mark = 8'd10;
    logic [CW-1:0] empty_mark = 8'd3;
    logic          tx_ack = 1'b0;
    logic          req_valid;
    logic [15:0]   req_quanta;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    pause_flow_ctrl #(.COUNT_W(CW), .INTERVAL_SHIFT(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .manual_en(manual_en),
        .auto_en(auto_en), .pause_time(pause_time), .buf_count(buf_count),
        .full_mark(full_mark), .empty_mark(empty_mark), .tx_ack(tx_ack),
        .req_valid(req_valid), .req_quanta(req_quanta)
    );

    function automatic int exp_interval(input int q);
        return q * 64;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack_now();
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    // counts negedges until req_valid is seen, up to lim
    task automatic wait_req(input int lim, output int n);
        n = 0;
        while (!req_valid && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        int p;
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));

        step(3);
        // R1: reset state
        check(req_valid == 1'b0, "R1 reset", int'(req_valid), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        step(2);
        check(req_valid == 1'b0, "R1 idle after reset", int'(req_valid), 0);

        // R2 / R3 / R10 / R4 with random quanta
        for (int it = 0; it < 4; it++) begin
            p = int'($urandom_range(1, 20));
            pause_time = 16'(p);
            manual_en = 1'b1;
            @(negedge clk);
            check(req_valid == 1'b1, "R2 manual request", int'(req_valid), 1);
            check(req_quanta == 16'(p), "R2 quanta", int'(req_quanta), p);
            pause_time = 16'(p + 100);
            step(int'($urandom_range(1, 4)));
            check(req_valid && req_quanta == 16'(p), "R3 R10 held", int'(req_quanta), p);
            ack_now();
            check(req_valid == 1'b0, "R3 drop after ack", int'(req_valid), 0);
            wait_req(5000, n);
            check(n == exp_interval(p), "R4 resend interval", n, exp_interval(p));
            check(req_quanta == 16'(p + 100), "R4 resend quanta", int'(req_quanta), p + 100);
            ack_now();
            manual_en = 1'b0;
            @(negedge clk);
            check(req_valid && req_quanta == 16'd0, "R6 release", int'(req_quanta), 0);
            ack_now();
            quiet(5, "R6 single release");
        end

        // R5: zero quanta -> no resend
        pause_time = 16'd0;
        manual_en = 1'b1;
        @(negedge clk);
        check(req_valid && req_quanta == 16'd0, "R5 zero frame", int'(req_valid), 1);
        ack_now();
        quiet(300, "R5 no resend");
        manual_en = 1'b0;
        @(negedge clk);
        ack_now();
        step(2);

        // R7 / R8: automatic hysteresis
        pause_time = 16'd200;
        auto_en = 1'b1;
        buf_count = 8'd5;
        quiet(5, "R7 below full");
        buf_count = 8'd10;
        @(negedge clk);
        check(req_valid == 1'b0, "R7 one-edge latency", int'(req_valid), 0);
        @(negedge clk);
        check(req_valid && req_quanta == 16'd200, "R7 auto assert", int'(req_quanta), 200);
        ack_now();
        buf_count = 8'd6;
        quiet(20, "R8 between marks");
        buf_count = 8'd3;
        @(negedge clk);
        check(req_valid == 1'b0, "R8 release latency", int'(req_valid), 0);
        @(negedge clk);
        check(req_valid && req_quanta == 16'd0, "R8 auto release", int'(req_quanta), 0);
        ack_now();
        buf_count = 8'd7;
        quiet(10, "R8 rising between marks");

        // R9: manual priority over automatic
        buf_count = 8'd12;
        step(2);
        check(req_valid == 1'b1, "R9 auto on", int'(req_valid), 1);
        ack_now();
        manual_en = 1'b1;
        quiet(10, "R9 manual on adds nothing");
        manual_en = 1'b0;
        quiet(10, "R9 manual off no release");
        auto_en = 1'b0;
        @(negedge clk);
        check(req_valid && req_quanta == 16'd0, "R9 release on auto off", int'(req_quanta), 0);
        ack_now();
        buf_count = 8'd0;

        // R1: disable drops pending request, no release
        pause_time = 16'd9;
        manual_en = 1'b1;
        @(negedge clk);
        check(req_valid == 1'b1, "R1 pre-disable request", int'(req_valid), 1);
        enable = 1'b0;
        @(negedge clk);
        check(req_valid == 1'b0, "R1 disable clears", int'(req_valid), 0);
        manual_en = 1'b0;
        quiet(10, "R1 no release while disabled");
        enable = 1'b1;
        quiet(10, "R1 no release after re-enable");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule